// File: doc/BRIEF.md
# CAN Controller Mode Handshake and Bit-Timing Configuration

This block sits between a host register bus and a CAN protocol engine. It holds the bit-timing settings (prescaler, the two time segments, the jump width and the triple-sampling select) and the drive style of the transmit pin. It also runs the move between configuration mode and normal mode.

The host sets a request bit to ask for configuration mode. The block grants the request through a status bit only when the protocol engine reports an idle bus, so that no frame is cut short. Timing registers accept writes only while that grant is shown. When the host clears the request, the grant drops, and the block then keeps the node off the bus. It lets the node join only after it has sampled eleven recessive bits in a row on the receive line.

From reset the node stays off the bus until one full enter-and-leave configuration cycle has completed. The transmit pin is modelled as a data output plus an output enable. In open-drain style the enable is raised only for dominant bits. In push-pull style the enable is always raised.

Top module: `can_mode_cfg`

## Requirements
- R1: After reset every readable register reads 0, the grant output is 0, the bus-join output is 0, the pin style is open drain, tx_o is 1 and tx_oe_o is 0.
- R2: Writing offset 0 with bit 7 set raises the request, which reads back in bit 7 of offset 0. The grant (bit 7 of offset 1, and cfg_mode_o) rises on the first clock edge at which the request is held and bus_idle_i is 1. It stays 0 while bus_idle_i is 0.
- R3: Writing offset 0 with bit 7 clear drops the request. The grant then falls on the next clock edge.
- R4: Writes to offsets 2 and 3 are ignored while the grant is 0.
- R5: Offset 2 holds the prescaler in bits 9:0. Offset 3 holds time segment 1 in bits 3:0, time segment 2 in bits 6:4, triple sampling in bit 7 and jump width in bits 9:8. Bits 15:10 of both read 0, and each field is driven on its own output.
- R6: After the grant falls, bus_on_o rises on the clock edge that takes the eleventh consecutive recessive bit (rx_valid_i=1, rx_bit_i=1). bus_on_o is 0 whenever the grant is 1.
- R7: While the block waits for an idle bus, a sampled dominant bit (rx_valid_i=1, rx_bit_i=0) restarts the count. Cycles with rx_valid_i=0 leave the count unchanged.
- R8: Before the first complete enter-and-leave configuration cycle since reset, bus_on_o stays 0 whatever the receive line shows.
- R9: Offset 4 bit 0 selects the pin style (0 open drain, 1 push-pull) and bits 15:1 read 0. Off the bus the driven bit is recessive (1). On the bus it is tx_bit_i. tx_o carries the driven bit. tx_oe_o is 1 in push-pull style; in open-drain style it is 1 only while the driven bit is 0.
- R10: A request made while on the bus is granted under the same idle rule, and bus_on_o falls on the edge at which the grant rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Host register offset |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data for addr_i |
| rx_bit_i | input | 1 | Sampled receive bit, 1 recessive |
| rx_valid_i | input | 1 | Strobe marking rx_bit_i as a new sampled bit |
| bus_idle_i | input | 1 | Protocol engine reports no frame in progress |
| tx_bit_i | input | 1 | Bit the protocol engine wants to send |
| cfg_mode_o | output | 1 | Configuration mode granted |
| bus_on_o | output | 1 | Node may take part in bus traffic |
| brp_o | output | 10 | Baud rate prescaler |
| tseg1_o | output | 4 | Time segment 1 |
| tseg2_o | output | 3 | Time segment 2 |
| sam_o | output | 1 | Triple sampling select |
| sjw_o | output | 2 | Synchronization jump width |
| tx_o | output | 1 | Transmit pin data |
| tx_oe_o | output | 1 | Transmit pin output enable |

## Verification
The assertions check on every cycle that the grant never rises without an idle bus, that it falls one edge after the request drops, and that the node is never on the bus while granted. They also check that the node only joins from the idle-wait state, that a dominant sample clears the count, that the timing registers hold while ungranted, and that the open-drain enable never drives a recessive bit. Only the bench's scenarios can show that the node never joins before the first configuration cycle. The same holds for the exact edge of joining across recessive runs of every length up to eleven, and for the bit layout of the timing registers, which the bench covers with full sweeps of all 1024 field patterns.

// File: rtl/can_mode_cfg_pkg.sv
package can_mode_cfg_pkg;
  localparam int unsigned AW    = 3;
  localparam int unsigned BRP_W = 10;
  localparam int unsigned SEG_W = 10;

  localparam logic [AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [AW-1:0] OFS_STAT = 3'd1;
  localparam logic [AW-1:0] OFS_TIM0 = 3'd2;
  localparam logic [AW-1:0] OFS_TIM1 = 3'd3;
  localparam logic [AW-1:0] OFS_PIN  = 3'd4;

  localparam int unsigned REQ_BIT = 7;
  localparam int unsigned ACK_BIT = 7;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CFG  = 2'd1,
    MODE_SYNC = 2'd2,
    MODE_ON   = 2'd3
  } mode_e;

  // packed order matches the register layout, lsb first: tseg1, tseg2, sam, sjw
  typedef struct packed {
    logic [1:0] sjw;
    logic       sam;
    logic [2:0] tseg2;
    logic [3:0] tseg1;
  } seg_cfg_t;
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import can_mode_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cfg_ack_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic [BRP_W-1:0]  brp_o,
  output seg_cfg_t          seg_o,
  output logic              push_pull_o
);
  logic             req_q, pp_q;
  logic [BRP_W-1:0] brp_q;
  seg_cfg_t         seg_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      pp_q  <= 1'b0;
      brp_q <= '0;
      seg_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_CTRL: req_q <= wdata_i[REQ_BIT];
        OFS_TIM0: if (cfg_ack_i) brp_q <= wdata_i[BRP_W-1:0];
        OFS_TIM1: if (cfg_ack_i) seg_q <= seg_cfg_t'(wdata_i[SEG_W-1:0]);
        OFS_PIN:  pp_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[REQ_BIT]     = req_q;
      OFS_STAT: rdata_o[ACK_BIT]     = cfg_ack_i;
      OFS_TIM0: rdata_o[BRP_W-1:0]   = brp_q;
      OFS_TIM1: rdata_o[SEG_W-1:0]   = seg_q;
      OFS_PIN:  rdata_o[0]           = pp_q;
      default: ;
    endcase
  end

  assign req_o       = req_q;
  assign brp_o       = brp_q;
  assign seg_o       = seg_q;
  assign push_pull_o = pp_q;

  a_r4_brp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ack_i |=> $stable(brp_q));
  a_r4_seg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ack_i |=> $stable(seg_q));
endmodule

// File: rtl/idle_detect.sv
module idle_detect #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = !clr_i && valid_i && bit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (valid_i) begin
      if (!bit_i)           cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r7_dominant_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && valid_i && !bit_i) |=> (cnt_q == '0));
  a_r7_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !valid_i) |=> $stable(cnt_q));
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import can_mode_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bus_idle_i,
  input  logic sync_done_i,
  output logic ack_o,
  output logic bus_on_o,
  output logic sync_clr_o
);
  mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_CFG:  if (!req_i) state_d = MODE_SYNC;
      MODE_SYNC: if (req_i && bus_idle_i) state_d = MODE_CFG;
                 else if (sync_done_i)    state_d = MODE_ON;
      default:   if (req_i && bus_idle_i) state_d = MODE_CFG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_OFF;
    else         state_q <= state_d;
  end

  assign ack_o      = (state_q == MODE_CFG);
  assign bus_on_o   = (state_q == MODE_ON);
  assign sync_clr_o = (state_q != MODE_SYNC);

  a_r2_wait_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && !bus_idle_i) |=> !ack_o);
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !req_i) |=> !ack_o);
  a_r6_off_when_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !bus_on_o);
  a_r8_join_from_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_on_o) |-> ($past(state_q) == MODE_SYNC));
endmodule

// File: rtl/tx_drive.sv
module tx_drive (
  input  logic rst_ni,
  input  logic push_pull_i,
  input  logic bus_on_i,
  input  logic tx_bit_i,
  output logic tx_o,
  output logic tx_oe_o
);
  logic drv_bit;

  // off the bus the node only ever shows recessive
  assign drv_bit = bus_on_i ? tx_bit_i : 1'b1;
  assign tx_o    = drv_bit;
  assign tx_oe_o = push_pull_i | ~drv_bit;

  always_comb begin
    if (rst_ni && !push_pull_i && !bus_on_i)
      a_r9_od_quiet_off_bus: assert (!tx_oe_o);
  end
endmodule

// File: rtl/can_mode_cfg.sv
module can_mode_cfg
  import can_mode_cfg_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_bit_i,
  input  logic              rx_valid_i,
  input  logic              bus_idle_i,
  input  logic              tx_bit_i,
  output logic              cfg_mode_o,
  output logic              bus_on_o,
  output logic [9:0]        brp_o,
  output logic [3:0]        tseg1_o,
  output logic [2:0]        tseg2_o,
  output logic              sam_o,
  output logic [1:0]        sjw_o,
  output logic              tx_o,
  output logic              tx_oe_o
);
  logic     req, ack, bus_on, sync_clr, sync_done, pp;
  seg_cfg_t seg;

  cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cfg_ack_i(ack), .rdata_o, .req_o(req), .brp_o,
    .seg_o(seg), .push_pull_o(pp)
  );

  mode_ctrl u_mode (
    .clk_i, .rst_ni, .req_i(req), .bus_idle_i,
    .sync_done_i(sync_done), .ack_o(ack), .bus_on_o(bus_on),
    .sync_clr_o(sync_clr)
  );

  idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni, .clr_i(sync_clr), .valid_i(rx_valid_i),
    .bit_i(rx_bit_i), .done_o(sync_done)
  );

  tx_drive u_tx (
    .rst_ni, .push_pull_i(pp), .bus_on_i(bus_on), .tx_bit_i,
    .tx_o, .tx_oe_o
  );

  assign cfg_mode_o = ack;
  assign bus_on_o   = bus_on;
  assign tseg1_o    = seg.tseg1;
  assign tseg2_o    = seg.tseg2;
  assign sam_o      = seg.sam;
  assign sjw_o      = seg.sjw;
endmodule

// File: tb/sim_can_mode_cfg.sv
module sim_can_mode_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_bit = 1'b1, rx_valid = 1'b0, bus_idle = 1'b0, tx_bit = 1'b1;
  logic        cfg_mode, bus_on, sam, tx, tx_oe;
  logic [9:0]  brp;
  logic [3:0]  tseg1;
  logic [2:0]  tseg2;
  logic [1:0]  sjw;

  int total = 0;
  int bad = 0;
  int run = 0;

  always #10 clk = ~clk;

  can_mode_cfg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_bit_i(rx_bit), .rx_valid_i(rx_valid),
    .bus_idle_i(bus_idle), .tx_bit_i(tx_bit), .cfg_mode_o(cfg_mode),
    .bus_on_o(bus_on), .brp_o(brp), .tseg1_o(tseg1), .tseg2_o(tseg2),
    .sam_o(sam), .sjw_o(sjw), .tx_o(tx), .tx_oe_o(tx_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  // one sampled bit; bench tracks consecutive recessive run
  task automatic rxbit(input logic b);
    rx_bit = b; rx_valid = 1'b1;
    step();
    rx_valid = 1'b0;
    run = b ? run + 1 : 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [15:0] keep_brp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), r);
      chk("R1 reg", r, 0);
    end
    chk("R1 grant", cfg_mode, 0);
    chk("R1 bus_on", bus_on, 0);
    chk("R1 tx", tx, 1);
    chk("R1 tx_oe", tx_oe, 0);

    // R8 no join before a configuration cycle
    bus_idle = 1'b1;
    for (int i = 0; i < 20; i++) rxbit(1'b1);
    chk("R8 bus_on without cfg", bus_on, 0);

    // R4 ignored while not granted
    wreg(3'd2, 16'h03ff);
    wreg(3'd3, 16'h03ff);
    rreg(3'd2, r); chk("R4 tim0 locked", r, 0);
    rreg(3'd3, r); chk("R4 tim1 locked", r, 0);

    // R2 grant waits for idle bus
    bus_idle = 1'b0;
    wreg(3'd0, 16'h0080);
    rreg(3'd0, r); chk("R2 request readback", r, 16'h0080);
    for (int i = 0; i < 4; i++) begin
      step();
      rreg(3'd1, r); chk("R2 no grant while busy", r, 0);
    end
    bus_idle = 1'b1;
    step();
    rreg(3'd1, r); chk("R2 grant status", r, 16'h0080);
    chk("R2 grant port", cfg_mode, 1);

    // R5 sweep all field patterns with reserved bits set
    for (int v = 0; v < 1024; v++) begin
      wreg(3'd2, 16'(v) | 16'hfc00);
      rreg(3'd2, r);
      chk("R5 tim0 readback", r, 32'(v));
      chk("R5 brp out", brp, 32'(v));
      wreg(3'd3, 16'(v) | 16'hac00);
      rreg(3'd3, r);
      chk("R5 tim1 readback", r, 32'(v));
      chk("R5 tseg1", tseg1, 32'(v % 16));
      chk("R5 tseg2", tseg2, 32'((v / 16) % 8));
      chk("R5 sam", sam, 32'((v / 128) % 2));
      chk("R5 sjw", sjw, 32'(v / 256));
    end
    wreg(3'd2, 16'h0003);
    keep_brp = 16'h0003;
    wreg(3'd3, 16'h03dc);

    // R3 grant falls one edge after request clears
    wreg(3'd0, 16'h0000);
    step();
    chk("R3 grant fell", cfg_mode, 0);
    rreg(3'd1, r); chk("R3 status", r, 0);

    // R4 locked again in normal mode
    wreg(3'd2, 16'h0155);
    rreg(3'd2, r); chk("R4 tim0 after exit", r, 32'(keep_brp));

    // R6 R7 runs of every length short of eleven, then the joining run
    run = 0;
    for (int k = 0; k <= 10; k++) begin
      for (int i = 0; i < k; i++) begin
        rxbit(1'b1);
        rx_bit = 1'b0; step(); // dominant without strobe: R7 ignored
        chk("R7 short run stays off", bus_on, 0);
      end
      rxbit(1'b0);
      chk("R7 dominant restarts", bus_on, 0);
    end
    for (int i = 0; i < 11; i++) begin
      rxbit(1'b1);
      chk("R6 join edge", bus_on, (run >= 11) ? 1 : 0);
    end
    rxbit(1'b0);
    chk("R6 stays on after join", bus_on, 1);

    // R9 drive styles while on the bus
    tx_bit = 1'b0; #1;
    chk("R9 od dominant tx", tx, 0);
    chk("R9 od dominant oe", tx_oe, 1);
    tx_bit = 1'b1; #1;
    chk("R9 od recessive oe", tx_oe, 0);
    wreg(3'd4, 16'hfffe);
    rreg(3'd4, r); chk("R9 pin reg bit0 clear", r, 0);
    wreg(3'd4, 16'hffff);
    rreg(3'd4, r); chk("R9 pin reg", r, 1);
    for (int b = 0; b < 2; b++) begin
      tx_bit = 1'(b); #1;
      chk("R9 pp tx", tx, 32'(b));
      chk("R9 pp oe", tx_oe, 1);
    end

    // R10 request while on bus: join drops with grant
    bus_idle = 1'b0;
    wreg(3'd0, 16'h0080);
    step();
    chk("R10 still on while busy", bus_on, 1);
    bus_idle = 1'b1;
    step();
    chk("R10 granted", cfg_mode, 1);
    chk("R10 off bus", bus_on, 0);
    tx_bit = 1'b0; #1;
    chk("R9 pp off bus recessive", tx, 1);
    wreg(3'd0, 16'h0000);
    step();
    run = 0;
    for (int i = 0; i < 11; i++) begin
      rxbit(1'b1);
      chk("R6 rejoin edge", bus_on, (run >= 11) ? 1 : 0);
    end

    finish_run();
  end
endmodule